// File: doc/BRIEF.md
# Interrupt-Driven Packet Receive Unit for a Mesh Network Interface

This unit sits between a mesh router's output port and a processor tile. It is the receive side of the network interface. It takes 64-bit flits from the router and treats the first flit of each packet as a header. It copies the header fields into receive registers that the processor can read, and it raises an interrupt. A short (single-flit) packet stays pending until the processor reads its data register. A bulk packet is held after its header until software writes a local start address. A small DMA engine then stores every body flit in consecutive memory words. Holding the bulk transfer this way means the network never writes into memory that software has not assigned.

A third kind of header carries a remote instruction for the interface itself. Such a packet never reaches the processor. Its 16-bit tag is decoded as an opcode that picks one of the interface's send-side registers, and the low 32 bits of the head flit are written into that register. A remote node can use this to set up where and how the tile will send its results.

Head flit layout: bits [63:56] are the packet type, bits [55:48] are routing offsets (not used here), bits [47:32] are the tag and bits [31:0] are the payload. The packet kind is type bits [1:0]: 0 is a short packet, 1 is a bulk packet, 2 is a remote instruction, and 3 is treated as a short packet.

Top module: `rx_depkt`

## Requirements
- R1: After reset, irq_o is 0, flit_ready_o is 1, mem_we_o is 0, every receive register reads 0, and every send register and snd_cmd_wr_o are 0.
- R2: When a short or bulk head flit is accepted, the receive registers capture type = flit[63:56], tag = flit[47:32] and payload = flit[31:0]. irq_o is 1 and flit_ready_o is 0 from the next cycle.
- R3: A pending short packet keeps irq_o high and flit_ready_o low through reads of other registers. A read of offset 0x28 consumes it, and from the next cycle irq_o is 0 and flit_ready_o is 1.
- R4: A pending bulk packet keeps irq_o high and flit_ready_o low, even through a read of 0x28, until software writes offset 0x2C. The payload read at 0x28 is the body flit count.
- R5: Body flit k (counting from 0) of a bulk packet is written to memory address base + k with the flit's 64 bits as data, where base is the value written to 0x2C. mem_we_o is high in the cycle after each body flit is accepted, and only then.
- R6: irq_o stays high until the last body write is presented, and it is 0 in that same cycle. A bulk packet with a count of 0 ends at the 0x2C write, with no memory write.
- R7: A type-kind-2 head is accepted without raising irq_o and leaves the receive registers unchanged. If tag[15:3] is 0, tag[2:0] selects a send register: 0 destination (8 bits), 1 id (16 bits), 2 data (32 bits), 3 read address (32 bits), 4 command (8 bits). That register takes the low bits of the payload, and a command write also makes snd_cmd_wr_o high for one cycle. Any other tag value changes nothing.
- R8: flit_ready_o is 0 exactly while a header awaits consumption or an address. It is 1 while idle and while body flits stream in.
- R9: Register reads return the type (zero-extended) at 0x20, the tag at 0x24, the payload at 0x28 and the last written address at 0x2C. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flit_valid_i | input | 1 | Router presents a flit |
| flit_i | input | 64 | Flit from router |
| flit_ready_o | output | 1 | Unit accepts the flit this cycle |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (same cycle) |
| irq_o | output | 1 | Packet awaiting processor |
| mem_we_o | output | 1 | Local memory write strobe |
| mem_addr_o | output | 32 | Local memory word address |
| mem_wdata_o | output | 64 | Local memory write data |
| snd_dest_o | output | 8 | Send destination register |
| snd_id_o | output | 16 | Send id/opcode register |
| snd_data_o | output | 32 | Send data/count register |
| snd_raddr_o | output | 32 | Send read-address register |
| snd_cmd_o | output | 8 | Send command register |
| snd_cmd_wr_o | output | 1 | One-cycle pulse on remote command write |

## Verification
The bench first reads the type and tag of a pending short packet and checks that the interrupt survives those reads. A design that consumed the packet on any read would drop irq_o too early. It then reads the payload of a bulk header before supplying an address. This catches a design that let the data-register read release a bulk packet, or that streamed body flits into memory at a stale address. A scoreboard compares every memory write against the expected base-plus-index address and data. The bench checks the interrupt after the second-to-last flit and after the last one, which exposes an off-by-one in the DMA count. A zero-count bulk packet must finish with no memory write. Remote instructions must leave irq_o low and the receive registers untouched, and an undefined opcode must change no send register.

// File: rtl/rx_depkt_pkg.sv
package rx_depkt_pkg;
  localparam int unsigned FLIT_W   = 64;
  localparam int unsigned TYPE_W   = 8;
  localparam int unsigned TAG_W    = 16;
  localparam int unsigned PAY_W    = 32;
  localparam int unsigned TYPE_LSB = FLIT_W - TYPE_W;
  localparam int unsigned TAG_LSB  = PAY_W;
  localparam int unsigned OFS_W    = 8;
  localparam int unsigned BUS_W    = 32;

  localparam logic [OFS_W-1:0] OFS_TYPE  = 8'h20;
  localparam logic [OFS_W-1:0] OFS_TAG   = 8'h24;
  localparam logic [OFS_W-1:0] OFS_DATA  = 8'h28;
  localparam logic [OFS_W-1:0] OFS_WADDR = 8'h2C;

  typedef enum logic [1:0] {
    PK_SINGLE = 2'd0,
    PK_BLOCK  = 2'd1,
    PK_CTRL   = 2'd2,
    PK_RSVD   = 2'd3
  } pkind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_RD,
    ST_WAIT_ADDR,
    ST_BODY
  } rx_state_e;

  typedef enum logic [2:0] {
    OP_DEST  = 3'd0,
    OP_ID    = 3'd1,
    OP_DATA  = 3'd2,
    OP_RADDR = 3'd3,
    OP_CMD   = 3'd4
  } ctl_op_e;
endpackage

// File: rtl/rx_seq.sv
module rx_seq
  import rx_depkt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_fire_i,
  input  pkind_e            kind_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [PAY_W-1:0]  pay_i,
  input  logic              rd_data_i,
  input  logic              wr_addr_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic              beat_i,
  input  logic              last_i,
  output rx_state_e         state_o,
  output logic              dma_start_o,
  output logic [TYPE_W-1:0] rx_type_o,
  output logic [TAG_W-1:0]  rx_tag_o,
  output logic [PAY_W-1:0]  rx_pay_o,
  output logic [AW-1:0]     rx_waddr_o
);
  rx_state_e state_q, state_d;
  logic      capture;

  assign capture     = head_fire_i && (kind_i != PK_CTRL);
  assign dma_start_o = (state_q == ST_WAIT_ADDR) && wr_addr_i && (rx_pay_o != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (head_fire_i) begin
          if (kind_i == PK_BLOCK)     state_d = ST_WAIT_ADDR;
          else if (kind_i != PK_CTRL) state_d = ST_WAIT_RD;
        end
      end
      ST_WAIT_RD:   if (rd_data_i) state_d = ST_IDLE;
      ST_WAIT_ADDR: if (wr_addr_i) state_d = (rx_pay_o == '0) ? ST_IDLE : ST_BODY;
      ST_BODY:      if (beat_i && last_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rx_type_o  <= '0;
      rx_tag_o   <= '0;
      rx_pay_o   <= '0;
      rx_waddr_o <= '0;
    end else begin
      state_q <= state_d;
      if (capture) begin
        rx_type_o <= type_i;
        rx_tag_o  <= tag_i;
        rx_pay_o  <= pay_i;
      end
      if (wr_addr_i) rx_waddr_o <= waddr_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/rx_dma.sv
module rx_dma
  import rx_depkt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_i,
  input  logic [PAY_W-1:0]  count_i,
  input  logic              beat_i,
  input  logic [FLIT_W-1:0] flit_i,
  output logic              last_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [FLIT_W-1:0] mem_wdata_o
);
  logic [AW-1:0]    ptr_q;
  logic [PAY_W-1:0] rem_q;

  assign last_o = (rem_q == PAY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      rem_q       <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= beat_i;
      if (start_i) begin
        ptr_q <= base_i;
        rem_q <= count_i;
      end else if (beat_i) begin
        ptr_q <= ptr_q + AW'(1);
        rem_q <= rem_q - PAY_W'(1);
      end
      if (beat_i) begin
        mem_addr_o  <= ptr_q;
        mem_wdata_o <= flit_i;
      end
    end
  end
endmodule

// File: rtl/rx_ctl_decode.sv
module rx_ctl_decode
  import rx_depkt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic [7:0]       snd_dest_o,
  output logic [15:0]      snd_id_o,
  output logic [31:0]      snd_data_o,
  output logic [31:0]      snd_raddr_o,
  output logic [7:0]       snd_cmd_o,
  output logic             snd_cmd_wr_o
);
  logic    legal;
  ctl_op_e op;

  assign legal = fire_i && (tag_i[TAG_W-1:3] == '0);
  assign op    = ctl_op_e'(tag_i[2:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snd_dest_o   <= '0;
      snd_id_o     <= '0;
      snd_data_o   <= '0;
      snd_raddr_o  <= '0;
      snd_cmd_o    <= '0;
      snd_cmd_wr_o <= 1'b0;
    end else begin
      snd_cmd_wr_o <= legal && (op == OP_CMD);
      if (legal) begin
        case (op)
          OP_DEST:  snd_dest_o  <= pay_i[7:0];
          OP_ID:    snd_id_o    <= pay_i[15:0];
          OP_DATA:  snd_data_o  <= pay_i;
          OP_RADDR: snd_raddr_o <= pay_i;
          OP_CMD:   snd_cmd_o   <= pay_i[7:0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_depkt.sv
module rx_depkt
  import rx_depkt_pkg::*;
#(
  parameter int unsigned MEM_AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flit_valid_i,
  input  logic [FLIT_W-1:0] flit_i,
  output logic              flit_ready_o,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [OFS_W-1:0]  bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [FLIT_W-1:0] mem_wdata_o,
  output logic [7:0]        snd_dest_o,
  output logic [15:0]       snd_id_o,
  output logic [31:0]       snd_data_o,
  output logic [31:0]       snd_raddr_o,
  output logic [7:0]        snd_cmd_o,
  output logic              snd_cmd_wr_o
);
  rx_state_e          state;
  pkind_e             kind;
  logic [TYPE_W-1:0]  h_type, rx_type;
  logic [TAG_W-1:0]   h_tag, rx_tag;
  logic [PAY_W-1:0]   h_pay, rx_pay;
  logic [MEM_AW-1:0]  rx_waddr, waddr_in;
  logic               head_fire, beat, ctl_fire, rd_data, wr_addr, dma_start, last;

  assign h_type = flit_i[FLIT_W-1:TYPE_LSB];
  assign h_tag  = flit_i[TAG_LSB+TAG_W-1:TAG_LSB];
  assign h_pay  = flit_i[PAY_W-1:0];
  assign kind   = pkind_e'(h_type[1:0]);

  assign flit_ready_o = (state == ST_IDLE) || (state == ST_BODY);
  assign irq_o        = (state != ST_IDLE);
  assign head_fire    = flit_valid_i && (state == ST_IDLE);
  assign beat         = flit_valid_i && (state == ST_BODY);
  assign ctl_fire     = head_fire && (kind == PK_CTRL);
  assign rd_data      = bus_req_i && !bus_we_i && (bus_addr_i == OFS_DATA);
  assign wr_addr      = bus_req_i && bus_we_i && (bus_addr_i == OFS_WADDR);
  assign waddr_in     = MEM_AW'(bus_wdata_i);

  rx_seq #(.AW(MEM_AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_fire_i (head_fire),
    .kind_i      (kind),
    .type_i      (h_type),
    .tag_i       (h_tag),
    .pay_i       (h_pay),
    .rd_data_i   (rd_data),
    .wr_addr_i   (wr_addr),
    .waddr_i     (waddr_in),
    .beat_i      (beat),
    .last_i      (last),
    .state_o     (state),
    .dma_start_o (dma_start),
    .rx_type_o   (rx_type),
    .rx_tag_o    (rx_tag),
    .rx_pay_o    (rx_pay),
    .rx_waddr_o  (rx_waddr)
  );

  rx_dma #(.AW(MEM_AW)) u_dma (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (dma_start),
    .base_i      (waddr_in),
    .count_i     (rx_pay),
    .beat_i      (beat),
    .flit_i      (flit_i),
    .last_o      (last),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  rx_ctl_decode u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (ctl_fire),
    .tag_i        (h_tag),
    .pay_i        (h_pay),
    .snd_dest_o   (snd_dest_o),
    .snd_id_o     (snd_id_o),
    .snd_data_o   (snd_data_o),
    .snd_raddr_o  (snd_raddr_o),
    .snd_cmd_o    (snd_cmd_o),
    .snd_cmd_wr_o (snd_cmd_wr_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFS_TYPE:  bus_rdata_o = BUS_W'(rx_type);
      OFS_TAG:   bus_rdata_o = BUS_W'(rx_tag);
      OFS_DATA:  bus_rdata_o = BUS_W'(rx_pay);
      OFS_WADDR: bus_rdata_o = BUS_W'(rx_waddr);
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rx_depkt_chk.sv
module rx_depkt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flit_valid_i,
  input logic [63:0] flit_i,
  input logic        flit_ready_o,
  input logic        bus_req_i,
  input logic        irq_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o
);
  logic acc_data, acc_ctl;
  assign acc_data = flit_valid_i && flit_ready_o && !irq_o && (flit_i[57:56] != 2'd2);
  assign acc_ctl  = flit_valid_i && flit_ready_o && !irq_o && (flit_i[57:56] == 2'd2);

  a_r8_stall_has_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flit_ready_o |-> irq_o);

  a_r3_pending_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flit_ready_o && !bus_req_i) |=> (irq_o && !flit_ready_o));

  a_r2_head_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_data |=> (irq_o && !flit_ready_o));

  a_r7_ctl_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ctl |=> !irq_o);

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 32'd1));

  a_r5_we_follows_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(flit_valid_i && flit_ready_o && irq_o));
endmodule

bind rx_depkt rx_depkt_chk u_chk (.*);

// File: tb/tb_rx_depkt.sv
module tb_rx_depkt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flit_valid_i = 1'b0;
  logic [63:0] flit_i = '0;
  logic        flit_ready_o;
  logic        bus_req_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, mem_we_o, snd_cmd_wr_o;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic [7:0]  snd_dest_o, snd_cmd_o;
  logic [15:0] snd_id_o;
  logic [31:0] snd_data_o, snd_raddr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_addr_q[$];
  logic [63:0] exp_data_q[$];

  always #10 clk_i = ~clk_i;

  rx_depkt dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_head(input logic [7:0] t, input logic [15:0] tag, input logic [31:0] pay);
    return {t, 8'h00, tag, pay};
  endfunction

  task automatic put_flit(input logic [63:0] f);
    @(negedge clk_i);
    flit_valid_i = 1'b1;
    flit_i = f;
    while (!flit_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    flit_valid_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_req_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  // scoreboard monitor for R5
  always @(negedge clk_i) begin
    if (rst_ni && mem_we_o) begin
      if (exp_addr_q.size() == 0) begin
        chk(1'b0, "R5 unexpected memory write", 64'(mem_addr_o), 64'hFFFF_FFFF);
      end else begin
        logic [31:0] ea;
        logic [63:0] ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        chk(mem_addr_o == ea, "R5 body address", 64'(mem_addr_o), 64'(ea));
        chk(mem_wdata_o == ed, "R5 body data", mem_wdata_o, ed);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq", 64'(irq_o), 64'd0);
    chk(flit_ready_o == 1'b1, "R1 ready", 64'(flit_ready_o), 64'd1);
    chk({snd_dest_o, snd_id_o, snd_data_o, snd_raddr_o, snd_cmd_o, snd_cmd_wr_o} == '0, "R1 send regs", 64'(snd_data_o), 64'd0);
    bus_rd(8'h20, d); chk(d == 32'd0, "R1 type reg", 64'(d), 64'd0);
    bus_rd(8'h28, d); chk(d == 32'd0, "R1 data reg", 64'(d), 64'd0);

    // short packet, R2 R3 R8 R9
    put_flit(mk_head(8'h40, 16'hBEEF, 32'hCAFE_0123));
    chk(irq_o == 1'b1, "R2 irq after head", 64'(irq_o), 64'd1);
    chk(flit_ready_o == 1'b0, "R8 ready low while pending", 64'(flit_ready_o), 64'd0);
    bus_rd(8'h20, d); chk(d == 32'h40, "R2 R9 type", 64'(d), 64'h40);
    bus_rd(8'h24, d); chk(d == 32'hBEEF, "R2 R9 tag", 64'(d), 64'hBEEF);
    chk(irq_o == 1'b1, "R3 irq held across other reads", 64'(irq_o), 64'd1);
    bus_rd(8'h28, d); chk(d == 32'hCAFE_0123, "R2 R9 payload", 64'(d), 64'hCAFE_0123);
    chk(irq_o == 1'b0, "R3 irq cleared by data read", 64'(irq_o), 64'd0);
    chk(flit_ready_o == 1'b1, "R3 ready restored", 64'(flit_ready_o), 64'd1);

    // reserved kind acts as short, R2
    put_flit(mk_head(8'h03, 16'h0001, 32'h5));
    chk(irq_o == 1'b1, "R2 reserved kind raises irq", 64'(irq_o), 64'd1);
    bus_rd(8'h28, d);
    chk(irq_o == 1'b0, "R3 reserved kind consumed", 64'(irq_o), 64'd0);

    // bulk packet, R4 R5 R6 R8
    put_flit(mk_head(8'h81, 16'h0077, 32'd3));
    bus_rd(8'h28, d); chk(d == 32'd3, "R4 count readable", 64'(d), 64'd3);
    chk(irq_o == 1'b1, "R4 data read does not release bulk", 64'(irq_o), 64'd1);
    chk(flit_ready_o == 1'b0, "R4 R8 ready low until address", 64'(flit_ready_o), 64'd0);
    bus_wr(8'h2C, 32'h0000_0100);
    chk(flit_ready_o == 1'b1, "R8 ready high during body", 64'(flit_ready_o), 64'd1);
    for (int k = 0; k < 3; k++) begin
      logic [63:0] f;
      f = {32'hD00D_0000 + 32'(k), 32'h1234_0000 ^ 32'(k * 7)};
      exp_addr_q.push_back(32'h100 + 32'(k));
      exp_data_q.push_back(f);
      put_flit(f);
      if (k == 1) chk(irq_o == 1'b1, "R6 irq held before last flit", 64'(irq_o), 64'd1);
    end
    chk(irq_o == 1'b0, "R6 irq low with last write", 64'(irq_o), 64'd0);
    chk(mem_we_o == 1'b1, "R5 last write presented", 64'(mem_we_o), 64'd1);
    bus_rd(8'h2C, d); chk(d == 32'h100, "R9 write address readback", 64'(d), 64'h100);

    // zero-count bulk, R6
    put_flit(mk_head(8'h01, 16'h0002, 32'd0));
    bus_wr(8'h2C, 32'h0000_0400);
    chk(irq_o == 1'b0, "R6 zero count ends at address write", 64'(irq_o), 64'd0);
    chk(flit_ready_o == 1'b1, "R6 ready after zero count", 64'(flit_ready_o), 64'd1);
    repeat (3) @(negedge clk_i);
    chk(exp_addr_q.size() == 0, "R6 no write for zero count", 64'(exp_addr_q.size()), 64'd0);

    // remote instructions, R7
    put_flit(mk_head(8'h02, 16'h0000, 32'h0000_005A));
    chk(irq_o == 1'b0, "R7 no irq", 64'(irq_o), 64'd0);
    chk(snd_dest_o == 8'h5A, "R7 dest", 64'(snd_dest_o), 64'h5A);
    put_flit(mk_head(8'h02, 16'h0001, 32'h0000_ABCD));
    chk(snd_id_o == 16'hABCD, "R7 id", 64'(snd_id_o), 64'hABCD);
    put_flit(mk_head(8'h02, 16'h0002, 32'h1111_2222));
    chk(snd_data_o == 32'h1111_2222, "R7 data", 64'(snd_data_o), 64'h1111_2222);
    put_flit(mk_head(8'h02, 16'h0003, 32'h0000_3000));
    chk(snd_raddr_o == 32'h3000, "R7 read address", 64'(snd_raddr_o), 64'h3000);
    put_flit(mk_head(8'h02, 16'h0004, 32'h0000_00C7));
    chk(snd_cmd_o == 8'hC7, "R7 command", 64'(snd_cmd_o), 64'hC7);
    chk(snd_cmd_wr_o == 1'b1, "R7 command pulse", 64'(snd_cmd_wr_o), 64'd1);
    @(negedge clk_i);
    chk(snd_cmd_wr_o == 1'b0, "R7 pulse one cycle", 64'(snd_cmd_wr_o), 64'd0);
    put_flit(mk_head(8'h02, 16'h0007, 32'hFFFF_FFFF));
    put_flit(mk_head(8'h02, 16'h0100, 32'hFFFF_FFFF));
    chk({snd_dest_o, snd_id_o, snd_data_o, snd_raddr_o, snd_cmd_o} == {8'h5A, 16'hABCD, 32'h1111_2222, 32'h3000, 8'hC7},
        "R7 undefined opcode ignored", 64'(snd_data_o), 64'h1111_2222);
    chk(snd_cmd_wr_o == 1'b0, "R7 no pulse on undefined opcode", 64'(snd_cmd_wr_o), 64'd0);
    bus_rd(8'h20, d); chk(d == 32'h01, "R7 receive type untouched", 64'(d), 64'h01);
    bus_rd(8'h24, d); chk(d == 32'h0002, "R7 receive tag untouched", 64'(d), 64'h0002);

    // unmapped offset, R9
    bus_rd(8'h30, d); chk(d == 32'd0, "R9 unmapped reads zero", 64'(d), 64'd0);

    repeat (4) @(negedge clk_i);
    chk(exp_addr_q.size() == 0, "R5 scoreboard drained", 64'(exp_addr_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule